// File: doc/BRIEF.md
# NAND Flash Device Command Front End

This block is the device-side command interface of a small-page NAND flash, with 528 bytes per page. The flash strobes are brought into the system clock domain before they reach it. A write strobe (active-low `we_n`) is sampled and acted on at its rising edge. With `cle` high the byte on `io_in` is a command. With `ale` high it is an address byte. With both low it is a data byte. Only command and address cycles require the chip enable `ce_n` to be low.

The block keeps a column pointer that selects one of three parts of the page. It collects address bytes and turns each completed sequence into one request to a back end that owns the array. It holds `rb` low while that request is outstanding. It drives the I/O bus when `re_n` is low, with one of three sources:
- array data from the back end,
- the two identification bytes,
- a status byte.

The control sequencer has these states:
- `S_IDLE`: waiting for a command.
- `S_ADDR`: collecting address bytes.
- `S_DIN`: accepting program data.
- `S_ERCONF`: waiting for the erase confirm.
- `S_BUSY`: a request is outstanding.
- `S_DOUT`: streaming read data.
- `S_IDOUT`: returning identification bytes.

Transitions between the states:
- Any state except `S_BUSY` goes to `S_ADDR` on a read, program, erase or ID command.
- `S_IDLE` and `S_DOUT` go to `S_ADDR` on a bare address byte.
- From `S_ADDR`, the final address byte leads to:
  - `S_BUSY` for a read,
  - `S_DIN` for a program,
  - `S_ERCONF` for an erase,
  - `S_IDOUT` for an ID command whose address byte is 00h,
  - `S_IDLE` for an ID command with any other address byte.
- `S_DIN` goes to `S_BUSY` on 10h.
- `S_ERCONF` goes to `S_BUSY` on D0h.
- `S_BUSY` goes on `req_ack` to `S_DOUT` after a read and to `S_IDLE` after a program or erase.

Top module: `nand_cmd_if`

## Requirements
- R1: A byte is taken on the cycle after `we_n` is seen rising. It is a command when `cle`=1, `ale`=0 and `ce_n`=0, and an address when `ale`=1, `cle`=0 and `ce_n`=0. A command strobed with `ce_n`=1 has no effect.
- R2: After reset, `rb`=1, `req_valid`=0 and `io_oe`=0. The pointer selects the first half of the page.
- R3: The pointer commands set `req_col` (10 bits) from the column byte C:
  - 00h gives C.
  - 01h gives 256+C.
  - 50h gives 512+C[3:0].
- R4: The 01h pointer serves one request and then returns to the first half. The 50h pointer stays until another pointer command arrives.
- R5: A read takes a column byte, then row bytes low first, with `req_row` = {high,low}. It then raises `req_valid` with `req_op`=0 and holds it stable with `rb`=0 until `req_ack`. After that, each `re_n` low returns `rd_data`, and each `re_n` rising pulses `rd_next`.
- R6: Address bytes with no command, in `S_IDLE` or `S_DOUT`, start another read in the current pointer area.
- R7: 80h, three address bytes, data bytes, then 10h. Each data byte pulses `wr_valid` with the byte on `wr_data`. The 10h issues `req_op`=1 with the same column mapping as a read.
- R8: 60h, two row bytes, then D0h issues `req_op`=2 with `req_col`=0.
- R9: 90h with address 00h makes RE reads return ECh, then E3h for every later read. This holds until the next accepted command. Address bytes do not change it.
- R10: 70h makes RE reads return status {1, ready, 00000b, fail}. Fail is `req_fail` captured at the acknowledge of the last program or erase.
- R11: While `rb`=0, only 70h is acted on. All other commands, including pointer commands, are ignored.
- R12: Command codes outside 00h, 01h, 50h, 80h, 10h, 60h, D0h, 90h and 70h leave the state and output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, active low |
| re_n | input | 1 | Read strobe, active low |
| io_in | input | 8 | Bus byte from the host |
| io_out | output | 8 | Bus byte to the host |
| io_oe | output | 1 | Bus output enable |
| rb | output | 1 | Ready (1) / busy (0) |
| req_valid | output | 1 | Operation request to back end |
| req_op | output | 2 | 0 read, 1 program, 2 erase |
| req_col | output | 10 | Column within the 528-byte page |
| req_row | output | 16 | Page address |
| req_ack | input | 1 | Back end finished the request |
| req_fail | input | 1 | Result of program/erase, valid with req_ack |
| rd_data | input | 8 | Current read byte from back end |
| rd_next | output | 1 | Advance read byte |
| wr_valid | output | 1 | Program data byte strobe |
| wr_data | output | 8 | Program data byte |

## Verification
A wrong pointer area shows up in `req_col` of the very next request, one cycle after its final address byte. A missed one-shot revert of the 01h pointer shows on the request after that. A sequencer left in the wrong state is seen on the next RE read, because the bus then carries array data, an ID byte or status in place of the expected one. A command wrongly taken while busy shows either as a lost status byte or as a changed column on the following read. The bench pairs every request with an expected entry and compares the op, column and row as soon as the request appears.

// File: rtl/nand_if_pkg.sv
package nand_if_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_DIN, S_ERCONF, S_BUSY, S_DOUT, S_IDOUT
    } seq_state_t;

    typedef enum logic [1:0] {
        AREA_LO, AREA_HI, AREA_SPARE
    } area_t;

    typedef enum logic [1:0] {
        OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_ID = 2'd3
    } op_t;

    localparam logic [7:0] C_PTR_LO    = 8'h00;
    localparam logic [7:0] C_PTR_HI    = 8'h01;
    localparam logic [7:0] C_PTR_SPARE = 8'h50;
    localparam logic [7:0] C_PROG      = 8'h80;
    localparam logic [7:0] C_PROG_GO   = 8'h10;
    localparam logic [7:0] C_ERASE     = 8'h60;
    localparam logic [7:0] C_ERASE_GO  = 8'hD0;
    localparam logic [7:0] C_IDENT     = 8'h90;
    localparam logic [7:0] C_STATUS    = 8'h70;

    localparam logic [7:0] ID_MAKER  = 8'hEC;
    localparam logic [7:0] ID_DEVICE = 8'hE3;

endpackage

// File: rtl/nand_edge.sv
module nand_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= strobe_n;
    end

    assign rise = strobe_n & ~prev_q;
endmodule

// File: rtl/nand_ptr.sv
module nand_ptr
    import nand_if_pkg::*;
#(
    parameter int SPARE_BITS = 4,
    localparam int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [7:0]       set_code,
    input  logic             consume,
    input  logic [7:0]       col_byte,
    output area_t            area,
    output logic [COL_W-1:0] col_full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            area <= AREA_LO;
        end else if (set_en) begin
            unique case (set_code)
                C_PTR_HI:    area <= AREA_HI;
                C_PTR_SPARE: area <= AREA_SPARE;
                default:     area <= AREA_LO;
            endcase
        end else if (consume && area == AREA_HI) begin
            area <= AREA_LO;
        end
    end

    always_comb begin
        unique case (area)
            AREA_HI:    col_full = {2'b01, col_byte};
            AREA_SPARE: col_full = {2'b10, {(8-SPARE_BITS){1'b0}}, col_byte[SPARE_BITS-1:0]};
            default:    col_full = {2'b00, col_byte};
        endcase
    end

    AST_HI_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !set_en && area == AREA_HI) |=> area == AREA_LO); // R4
    AST_SPARE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (area == AREA_SPARE && !set_en) |=> area == AREA_SPARE); // R4
endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_if_pkg::*;
#(
    parameter int ROW_BYTES = 2,
    localparam int ROW_W  = 8 * ROW_BYTES,
    localparam int ACNT_W = $clog2(ROW_BYTES + 2),
    localparam int COL_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_stb,
    input  logic             adr_stb,
    input  logic             dat_stb,
    input  logic             re_rise,
    input  logic [7:0]       io_in,
    input  logic [COL_W-1:0] col_full,
    input  logic             req_ack,
    input  logic             req_fail,
    output seq_state_t       state,
    output logic [7:0]       col_q,
    output logic             ptr_set,
    output logic             ptr_consume,
    output logic             req_valid,
    output logic [1:0]       req_op,
    output logic [COL_W-1:0] req_col,
    output logic [ROW_W-1:0] req_row,
    output logic             stat_sel,
    output logic             fail_flag,
    output logic             id_second,
    output logic             rd_next,
    output logic             wr_valid,
    output logic [7:0]       wr_data
);
    seq_state_t        nxt;
    op_t               kind;
    logic [ACNT_W-1:0] acnt, last_idx, row_idx;
    logic              cmd_ok, is_ptr, start_rd, start_pg, start_er, start_id, start_any;
    logic              stat_cmd, conf_pg, conf_er, auto_rd, addr_in, last_addr, go_busy;

    assign cmd_ok    = cmd_stb && state != S_BUSY;
    assign is_ptr    = io_in == C_PTR_LO || io_in == C_PTR_HI || io_in == C_PTR_SPARE;
    assign start_rd  = cmd_ok && is_ptr;
    assign start_pg  = cmd_ok && io_in == C_PROG;
    assign start_er  = cmd_ok && io_in == C_ERASE;
    assign start_id  = cmd_ok && io_in == C_IDENT;
    assign start_any = start_rd || start_pg || start_er || start_id;
    assign stat_cmd  = cmd_stb && io_in == C_STATUS;
    assign conf_pg   = cmd_ok && io_in == C_PROG_GO && state == S_DIN;
    assign conf_er   = cmd_ok && io_in == C_ERASE_GO && state == S_ERCONF;
    assign auto_rd   = adr_stb && (state == S_IDLE || state == S_DOUT);
    assign addr_in   = adr_stb && state == S_ADDR;

    always_comb begin
        unique case (kind)
            OP_ERASE: last_idx = ACNT_W'(ROW_BYTES - 1);
            OP_ID:    last_idx = '0;
            default:  last_idx = ACNT_W'(ROW_BYTES);
        endcase
    end
    assign row_idx   = (kind == OP_ERASE) ? acnt : acnt - 1'b1;
    assign last_addr = addr_in && acnt == last_idx;
    assign go_busy   = (last_addr && kind == OP_READ) || conf_pg || conf_er;

    always_comb begin
        nxt = state;
        unique case (state)
            S_BUSY: begin
                if (req_ack) nxt = (kind == OP_READ) ? S_DOUT : S_IDLE;
            end
            S_IDLE, S_ADDR, S_DIN, S_ERCONF, S_DOUT, S_IDOUT: begin
                if (start_any)    nxt = S_ADDR;
                else if (go_busy) nxt = S_BUSY;
                else if (auto_rd) nxt = S_ADDR;
                else if (last_addr) begin
                    unique case (kind)
                        OP_PROG:  nxt = S_DIN;
                        OP_ERASE: nxt = S_ERCONF;
                        default:  nxt = (io_in == 8'h00) ? S_IDOUT : S_IDLE;
                    endcase
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind <= OP_READ; acnt <= '0; col_q <= '0; req_row <= '0;
            req_op <= '0; req_col <= '0; stat_sel <= 1'b0; fail_flag <= 1'b0;
            id_second <= 1'b0; rd_next <= 1'b0; wr_valid <= 1'b0; wr_data <= '0;
        end else begin
            rd_next  <= re_rise && state == S_DOUT && !stat_sel;
            wr_valid <= dat_stb && state == S_DIN;
            if (dat_stb && state == S_DIN) wr_data <= io_in;

            if (start_any) begin
                acnt <= '0;
                if (start_er) col_q <= '0;
                kind <= start_pg ? OP_PROG : start_er ? OP_ERASE : start_id ? OP_ID : OP_READ;
            end else if (auto_rd) begin
                kind <= OP_READ; acnt <= ACNT_W'(1); col_q <= io_in;
            end else if (addr_in) begin
                acnt <= acnt + 1'b1;
                if (kind != OP_ID) begin
                    if (kind != OP_ERASE && acnt == '0) col_q <= io_in;
                    for (int b = 0; b < ROW_BYTES; b++) begin
                        if ((kind == OP_ERASE || acnt != '0) && row_idx == ACNT_W'(b))
                            req_row[8*b +: 8] <= io_in;
                    end
                end
            end

            if (go_busy) begin
                req_op  <= (kind == OP_READ) ? 2'd0 : conf_pg ? 2'd1 : 2'd2;
                req_col <= (kind == OP_ERASE) ? '0 : col_full;
            end

            if (start_any || go_busy) stat_sel <= 1'b0;
            else if (stat_cmd)        stat_sel <= 1'b1;

            if (state == S_BUSY && req_ack && kind != OP_READ) fail_flag <= req_fail;

            if (start_id) id_second <= 1'b0;
            else if (re_rise && state == S_IDOUT && !stat_sel) id_second <= 1'b1;
        end
    end

    assign ptr_set     = start_rd;
    assign ptr_consume = go_busy;
    assign req_valid   = state == S_BUSY;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> req_valid && $stable(req_op) && $stable(req_col) && $stable(req_row)); // R5
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> !req_valid); // R5
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_next, wr_valid})); // R7
endmodule

// File: rtl/nand_cmd_if.sv
module nand_cmd_if
    import nand_if_pkg::*;
#(
    parameter int ROW_BYTES  = 2,
    parameter int SPARE_BITS = 4,
    localparam int ROW_W = 8 * ROW_BYTES,
    localparam int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             cle,
    input  logic             ale,
    input  logic             we_n,
    input  logic             re_n,
    input  logic [7:0]       io_in,
    output logic [7:0]       io_out,
    output logic             io_oe,
    output logic             rb,
    output logic             req_valid,
    output logic [1:0]       req_op,
    output logic [COL_W-1:0] req_col,
    output logic [ROW_W-1:0] req_row,
    input  logic             req_ack,
    input  logic             req_fail,
    input  logic [7:0]       rd_data,
    output logic             rd_next,
    output logic             wr_valid,
    output logic [7:0]       wr_data
);
    logic [1:0]       rise;
    logic             cmd_stb, adr_stb, dat_stb;
    logic             ptr_set, ptr_consume, stat_sel, fail_flag, id_second;
    logic [7:0]       col_q;
    logic [COL_W-1:0] col_full;
    area_t            area;
    seq_state_t       state;

    nand_edge #(.N(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .strobe_n({re_n, we_n}), .rise(rise)
    );

    assign cmd_stb = rise[0] && cle && !ale && !ce_n;
    assign adr_stb = rise[0] && ale && !cle && !ce_n;
    assign dat_stb = rise[0] && !cle && !ale;

    nand_ptr #(.SPARE_BITS(SPARE_BITS)) u_ptr (
        .clk(clk), .rst_n(rst_n), .set_en(ptr_set), .set_code(io_in),
        .consume(ptr_consume), .col_byte(col_q), .area(area), .col_full(col_full)
    );

    nand_seq #(.ROW_BYTES(ROW_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .adr_stb(adr_stb),
        .dat_stb(dat_stb), .re_rise(rise[1]), .io_in(io_in), .col_full(col_full),
        .req_ack(req_ack), .req_fail(req_fail), .state(state), .col_q(col_q),
        .ptr_set(ptr_set), .ptr_consume(ptr_consume), .req_valid(req_valid),
        .req_op(req_op), .req_col(req_col), .req_row(req_row), .stat_sel(stat_sel),
        .fail_flag(fail_flag), .id_second(id_second), .rd_next(rd_next),
        .wr_valid(wr_valid), .wr_data(wr_data)
    );

    assign rb    = state != S_BUSY;
    assign io_oe = !re_n && !ce_n;

    always_comb begin
        if (stat_sel)              io_out = {1'b1, rb, 5'b0, fail_flag};
        else if (state == S_IDOUT) io_out = id_second ? ID_DEVICE : ID_MAKER;
        else                       io_out = rd_data;
    end

    AST_BUSY_AREA: assert property (@(posedge clk) disable iff (!rst_n)
        !rb |=> $stable(area)); // R11
    AST_ID_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDOUT && !stat_sel) |-> (io_out == ID_MAKER || io_out == ID_DEVICE)); // R9
endmodule

// File: tb/tb_nand_cmd_if.sv
module tb_nand_cmd_if;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic io_oe, rb, req_valid, rd_next, wr_valid;
    logic [1:0] req_op;
    logic [9:0] req_col;
    logic [15:0] req_row;
    logic req_ack = 1'b0, req_fail = 1'b0;
    logic [7:0] rd_data = 8'h40;
    logic [7:0] wr_data;

    int errs = 0, checks = 0;
    int ack_dly = 3;
    int wait_cnt = 0;
    logic taken = 1'b0;
    bit done = 0;

    typedef struct { logic [1:0] op; logic [9:0] col; logic [15:0] row; string tag; } req_t;
    req_t exp_q[$];
    logic [7:0] wr_got[$];

    always #2.5 clk = ~clk;

    nand_cmd_if dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rb(rb),
        .req_valid(req_valid), .req_op(req_op), .req_col(req_col), .req_row(req_row),
        .req_ack(req_ack), .req_fail(req_fail), .rd_data(rd_data), .rd_next(rd_next),
        .wr_valid(wr_valid), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_req(input logic [1:0] op, input logic [9:0] col,
                            input logic [15:0] row, input string tag);
        req_t r;
        r.op = op; r.col = col; r.row = row; r.tag = tag;
        exp_q.push_back(r);
    endtask

    // Scoreboard monitor and back-end model
    always @(negedge clk) begin
        if (!rst_n) begin
            req_ack <= 1'b0; taken <= 1'b0;
        end else if (req_ack) begin
            req_ack <= 1'b0;
        end else if (req_valid) begin
            if (!taken) begin
                taken <= 1'b1;
                wait_cnt <= ack_dly;
                if (exp_q.size() == 0) begin
                    chk(0, "unexpected request", req_op, 0);
                end else begin
                    req_t e;
                    e = exp_q.pop_front();
                    chk(req_op == e.op,   {e.tag, " op"},  req_op,  e.op);
                    chk(req_col == e.col, {e.tag, " col"}, req_col, e.col);
                    chk(req_row == e.row, {e.tag, " row"}, req_row, e.row);
                end
            end else if (wait_cnt == 0) begin
                req_ack <= 1'b1;
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end else begin
            taken <= 1'b0;
        end
        if (wr_valid) wr_got.push_back(wr_data);
    end

    always @(posedge clk) if (rd_next) rd_data <= rd_data + 8'h01;

    task automatic strobe(input logic c, input logic a, input logic [7:0] b);
        @(negedge clk); cle = c; ale = a; io_in = b; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); cle = 1'b0; ale = 1'b0;
    endtask
    task automatic cmd(input logic [7:0] b);  strobe(1'b1, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b);  strobe(1'b0, 1'b1, b); endtask
    task automatic din(input logic [7:0] b);  strobe(1'b0, 1'b0, b); endtask

    task automatic rd_byte(output logic [7:0] v);
        @(negedge clk); re_n = 1'b0;
        @(negedge clk); v = io_out;
        re_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 300 && !rb; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rb == 1'b1, "R2 ready after reset", rb, 1);
        chk(req_valid == 1'b0, "R2 no request after reset", req_valid, 0);
        chk(io_oe == 1'b0, "R2 bus idle after reset", io_oe, 0);

        // R2 R6: bare address bytes read in default first-half area
        push_req(2'd0, 10'h012, 16'h5634, "R2 R6 default read");
        adr(8'h12); adr(8'h34);
        chk(rb == 1'b1, "R5 ready before last address", rb, 1);
        adr(8'h56);
        chk(rb == 1'b0, "R5 busy after read address", rb, 0);
        wait_ready();
        rd_byte(v); chk(v == 8'h40, "R5 first read byte", v, 8'h40);
        rd_byte(v); chk(v == 8'h41, "R5 second read byte", v, 8'h41);
        chk(io_oe == 1'b0, "R5 bus released", io_oe, 0);

        // R3 R4: second-half pointer, then revert
        push_req(2'd0, 10'h105, 16'h0001, "R3 second half");
        cmd(8'h01); adr(8'h05); adr(8'h01); adr(8'h00); wait_ready();
        push_req(2'd0, 10'h007, 16'h0000, "R4 01h one-shot revert");
        adr(8'h07); adr(8'h00); adr(8'h00); wait_ready();

        // R3 R4: spare pointer persists
        push_req(2'd0, 10'h20F, 16'h0002, "R3 spare mapping");
        cmd(8'h50); adr(8'h1F); adr(8'h02); adr(8'h00); wait_ready();
        push_req(2'd0, 10'h203, 16'h0000, "R4 50h persists");
        adr(8'h03); adr(8'h00); adr(8'h00); wait_ready();
        push_req(2'd0, 10'h0AA, 16'h0010, "R3 first half");
        cmd(8'h00); adr(8'hAA); adr(8'h10); adr(8'h00); wait_ready();

        // R7: program with failing result
        req_fail = 1'b1;
        push_req(2'd1, 10'h020, 16'h0001, "R7 program");
        cmd(8'h80); adr(8'h20); adr(8'h01); adr(8'h00);
        din(8'h11); din(8'h22);
        cmd(8'h10); wait_ready();
        chk(wr_got.size() == 2, "R7 data byte count", wr_got.size(), 2);
        if (wr_got.size() == 2) begin
            chk(wr_got[0] == 8'h11, "R7 data byte 0", wr_got[0], 8'h11);
            chk(wr_got[1] == 8'h22, "R7 data byte 1", wr_got[1], 8'h22);
        end
        cmd(8'h70); rd_byte(v);
        chk(v == 8'hC1, "R10 status after failed program", v, 8'hC1);

        // R8 R11: erase with long busy, commands during busy
        req_fail = 1'b0; ack_dly = 40;
        push_req(2'd2, 10'h000, 16'h0008, "R8 erase");
        cmd(8'h60); adr(8'h08); adr(8'h00); cmd(8'hD0);
        chk(rb == 1'b0, "R8 busy after confirm", rb, 0);
        cmd(8'h70); rd_byte(v);
        chk(v == 8'h81, "R11 status accepted while busy", v, 8'h81);
        cmd(8'h50); cmd(8'h90);
        rd_byte(v);
        chk(v == 8'h81, "R11 commands ignored while busy", v, 8'h81);
        wait_ready(); ack_dly = 3;
        rd_byte(v);
        chk(v == 8'hC0, "R10 status after passing erase", v, 8'hC0);
        push_req(2'd0, 10'h009, 16'h0000, "R11 pointer unchanged by busy 50h");
        adr(8'h09); adr(8'h00); adr(8'h00); wait_ready();

        // R9 R12 R1: identification
        cmd(8'h90); adr(8'h00);
        rd_byte(v); chk(v == 8'hEC, "R9 first id byte", v, 8'hEC);
        rd_byte(v); chk(v == 8'hE3, "R9 second id byte", v, 8'hE3);
        rd_byte(v); chk(v == 8'hE3, "R9 later id byte", v, 8'hE3);
        adr(8'h77);
        rd_byte(v); chk(v == 8'hE3, "R9 address ignored in id", v, 8'hE3);
        chk(rb == 1'b1, "R9 no request from id address", rb, 1);
        cmd(8'h33);
        rd_byte(v); chk(v == 8'hE3, "R12 unknown command ignored", v, 8'hE3);
        ce_n = 1'b1; cmd(8'h70); ce_n = 1'b0;
        rd_byte(v); chk(v == 8'hE3, "R1 command with chip disabled ignored", v, 8'hE3);
        cmd(8'h70);
        rd_byte(v); chk(v == 8'hC0, "R1 R10 status command taken", v, 8'hC0);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all expected requests seen", exp_q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule